// File: doc/BRIEF.md
# Synchronous Burst Cache-Fill Bus Master

This block is the master side of a 32-bit synchronous processor bus. The core hands it one request at a time: a byte address, a function code, a transfer size, a read/write flag, write data and a flag that asks for a whole cache line. The block raises the strobes and drives the request onto the bus. Each clock it samples the slave's terminate, burst-acknowledge, bus-error, halt and cache-inhibit inputs, and it finishes with a done pulse that carries an error or retry status.

A line-fill read may grow into a burst. This happens only when the first beat ends synchronously while the slave acknowledges the burst and does not inhibit caching. During a burst the strobes, direction, address, function code and size stay frozen. A word is captured on every clock that has terminate high, until four words have arrived or the slave cuts the burst short.

Each captured read word goes back to the core with its position in the line. The position wraps from the word that missed. A mask of the line positions actually transferred is reported, so the core can tell a complete fill from a partial one. All bus inputs and outputs are active high, and `bus_rw` is 1 for a read.

Top module: `sbf_bus_master`

## Requirements
- R1: While reset is high and in the first cycle after it, `bus_as`, `bus_ds`, `bus_breq`, `rsp_beat_valid`, `rsp_done`, `rsp_err` and `rsp_retry` are 0 and `req_ready` is 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle `bus_as` and `bus_ds` are 1, `bus_addr`, `bus_fc` and `bus_size` carry the request, `bus_rw` is the inverse of `req_write`, and `req_ready` stays 0 until the cycle after the transfer ends.
- R3: A clock edge with `bus_term` sampled 1 ends a beat, and each clock without it is a wait state. The shortest cycle therefore has terminate high at the first edge after the strobes rise. At the edge that ends a transfer, `rsp_done` pulses for one cycle while `bus_as` and `bus_ds` fall.
- R4: For a read, each edge that captures a beat is followed by a one-cycle `rsp_beat_valid` pulse, with `rsp_beat_data` equal to `bus_rdata` as sampled at that edge.
- R5: `bus_berr` with `bus_halt` ends the transfer with `rsp_retry`. `bus_berr` alone ends it with `rsp_err`. In both cases no word is captured in that clock, even if `bus_term` is also high.
- R6: `bus_breq` rises with the strobes only for a read with `req_fill` set. It falls after the third word of a burst is captured, or when the transfer ends, whichever comes first.
- R7: A burst follows only if the first beat ends with `bus_term` high, `bus_breq` high, `bus_back` high and `bus_cinh` low. Otherwise the transfer ends after that one beat.
- R8: During a burst, `bus_addr` and `bus_rw` stay unchanged, and a word is captured on each clock with `bus_term` high. After the fourth word the transfer ends with `rsp_mask` equal to 4'hF.
- R9: In a burst clock after the first beat, `bus_cinh` high or `bus_back` low (without `bus_berr`) ends the transfer with no status flag and no capture in that clock. `rsp_mask` then shows only the words already captured.
- R10: Beat n (counting from 0) carries line position `rsp_beat_idx` = (`req_addr[3:2]` + n) mod 4. At `rsp_done`, bit k of `rsp_mask` is 1 exactly when line position k was transferred.
- R11: A write drives `bus_rw` 0, puts `req_wdata` on `bus_wdata`, never raises `bus_breq` (even with `req_fill` set), and never pulses `rsp_beat_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | AW | Byte address |
| req_fc | input | FCW | Function code |
| req_size | input | SZW | Transfer size code |
| req_write | input | 1 | 1 = write |
| req_fill | input | 1 | Ask for a cache-line burst |
| req_wdata | input | DW | Write data |
| bus_as | output | 1 | Address strobe |
| bus_ds | output | 1 | Data strobe |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_addr | output | AW | Bus address |
| bus_fc | output | FCW | Bus function code |
| bus_size | output | SZW | Bus size code |
| bus_wdata | output | DW | Bus write data |
| bus_breq | output | 1 | Burst request |
| bus_rdata | input | DW | Bus read data |
| bus_term | input | 1 | Synchronous terminate |
| bus_back | input | 1 | Burst acknowledge |
| bus_berr | input | 1 | Bus error |
| bus_halt | input | 1 | Halt, with bus error means retry |
| bus_cinh | input | 1 | Cache inhibit |
| rsp_beat_valid | output | 1 | Read word returned this cycle |
| rsp_beat_data | output | DW | Returned word |
| rsp_beat_idx | output | IW | Line position of the returned word |
| rsp_done | output | 1 | Transfer finished |
| rsp_err | output | 1 | Finished with bus error |
| rsp_retry | output | 1 | Finished with retry |
| rsp_mask | output | LINE_WORDS | Line positions transferred |

## Verification
A beat counter that is off by one shows up within a single beat. The wrong `rsp_beat_idx` appears on the very next returned word, the full-line done comes one capture early or late, and `bus_breq` falls at the wrong edge. If the stop decode is wrong, the mask reported with `rsp_done` is wrong in the same cycle, or a pulse of `rsp_beat_valid` follows a clock that should have captured nothing. Because every response is registered, the bench compares each one exactly one edge after the input pattern that caused it.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  typedef enum logic [2:0] {
    EV_NONE,
    EV_BEAT,
    EV_ERR,
    EV_RETRY,
    EV_STOP
  } sbf_event_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIRST,
    ST_BURST
  } sbf_state_e;
endpackage

// File: rtl/sbf_term_classify.sv
module sbf_term_classify
  import sbf_pkg::*;
(
  input  logic       first,
  input  logic       want_burst,
  input  logic       term,
  input  logic       back,
  input  logic       berr,
  input  logic       halt,
  input  logic       cinh,
  output sbf_event_e ev,
  output logic       cont
);
  always_comb begin
    if (berr)                      ev = halt ? EV_RETRY : EV_ERR;
    else if (!first && (cinh || !back)) ev = EV_STOP;
    else if (term)                 ev = EV_BEAT;
    else                           ev = EV_NONE;
  end

  // Burst may continue only from a clean synchronous first beat
  assign cont = first && term && !berr && want_burst && back && !cinh;
endmodule

// File: rtl/sbf_beat_track.sv
module sbf_beat_track #(
  parameter int LINE_WORDS = 4,
  localparam int IW = $clog2(LINE_WORDS),
  localparam int CW = $clog2(LINE_WORDS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [IW-1:0]         start_idx,
  input  logic                  advance,
  output logic [IW-1:0]         cur_idx,
  output logic                  at_last,
  output logic                  before_last,
  output logic [LINE_WORDS-1:0] mask
);
  logic [IW-1:0] start_q;
  logic [CW-1:0] count_q;

  assign cur_idx     = start_q + count_q[IW-1:0];
  assign at_last     = (count_q == CW'(LINE_WORDS - 1));
  assign before_last = (count_q == CW'(LINE_WORDS - 2));

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      count_q <= '0;
    end else if (load) begin
      start_q <= start_idx;
      count_q <= '0;
    end else if (advance) begin
      count_q <= count_q + 1'b1;
    end
  end

  for (genvar k = 0; k < LINE_WORDS; k++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst || load)                         mask[k] <= 1'b0;
      else if (advance && cur_idx == IW'(k))   mask[k] <= 1'b1;
    end
  end
endmodule

// File: rtl/sbf_bus_master.sv
module sbf_bus_master
  import sbf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int FCW = 3,
  parameter int SZW = 2,
  parameter int LINE_WORDS = 4,
  localparam int IW = $clog2(LINE_WORDS),
  localparam int BSH = $clog2(DW / 8)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [AW-1:0]         req_addr,
  input  logic [FCW-1:0]        req_fc,
  input  logic [SZW-1:0]        req_size,
  input  logic                  req_write,
  input  logic                  req_fill,
  input  logic [DW-1:0]         req_wdata,
  output logic                  bus_as,
  output logic                  bus_ds,
  output logic                  bus_rw,
  output logic [AW-1:0]         bus_addr,
  output logic [FCW-1:0]        bus_fc,
  output logic [SZW-1:0]        bus_size,
  output logic [DW-1:0]         bus_wdata,
  output logic                  bus_breq,
  input  logic [DW-1:0]         bus_rdata,
  input  logic                  bus_term,
  input  logic                  bus_back,
  input  logic                  bus_berr,
  input  logic                  bus_halt,
  input  logic                  bus_cinh,
  output logic                  rsp_beat_valid,
  output logic [DW-1:0]         rsp_beat_data,
  output logic [IW-1:0]         rsp_beat_idx,
  output logic                  rsp_done,
  output logic                  rsp_err,
  output logic                  rsp_retry,
  output logic [LINE_WORDS-1:0] rsp_mask
);
  sbf_state_e    state_q;
  sbf_event_e    ev;
  logic          cont, active, take, advance, finish;
  logic [IW-1:0] cur_idx;
  logic          at_last, before_last;

  assign active    = (state_q != ST_IDLE);
  assign req_ready = (state_q == ST_IDLE);
  assign take      = req_ready && req_valid;
  assign advance   = active && (ev == EV_BEAT);

  sbf_term_classify u_classify (
    .first      (state_q == ST_FIRST),
    .want_burst (bus_breq),
    .term       (bus_term),
    .back       (bus_back),
    .berr       (bus_berr),
    .halt       (bus_halt),
    .cinh       (bus_cinh),
    .ev         (ev),
    .cont       (cont)
  );

  sbf_beat_track #(.LINE_WORDS(LINE_WORDS)) u_track (
    .clk         (clk),
    .rst         (rst),
    .load        (take),
    .start_idx   (req_addr[BSH +: IW]),
    .advance     (advance),
    .cur_idx     (cur_idx),
    .at_last     (at_last),
    .before_last (before_last),
    .mask        (rsp_mask)
  );

  always_comb begin
    finish = 1'b0;
    if (active) begin
      case (ev)
        EV_BEAT:                   finish = (state_q == ST_FIRST) ? !cont : at_last;
        EV_ERR, EV_RETRY, EV_STOP: finish = 1'b1;
        default:                   finish = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_IDLE;
      bus_as         <= 1'b0;
      bus_ds         <= 1'b0;
      bus_rw         <= 1'b1;
      bus_addr       <= '0;
      bus_fc         <= '0;
      bus_size       <= '0;
      bus_wdata      <= '0;
      bus_breq       <= 1'b0;
      rsp_beat_valid <= 1'b0;
      rsp_beat_data  <= '0;
      rsp_beat_idx   <= '0;
      rsp_done       <= 1'b0;
      rsp_err        <= 1'b0;
      rsp_retry      <= 1'b0;
    end else begin
      rsp_beat_valid <= 1'b0;
      rsp_done       <= 1'b0;
      rsp_err        <= 1'b0;
      rsp_retry      <= 1'b0;
      if (take) begin
        state_q   <= ST_FIRST;
        bus_as    <= 1'b1;
        bus_ds    <= 1'b1;
        bus_rw    <= !req_write;
        bus_addr  <= req_addr;
        bus_fc    <= req_fc;
        bus_size  <= req_size;
        bus_wdata <= req_wdata;
        bus_breq  <= req_fill && !req_write;
      end else if (active) begin
        if (advance && bus_rw) begin
          rsp_beat_valid <= 1'b1;
          rsp_beat_data  <= bus_rdata;
          rsp_beat_idx   <= cur_idx;
        end
        if (finish) begin
          state_q   <= ST_IDLE;
          bus_as    <= 1'b0;
          bus_ds    <= 1'b0;
          bus_breq  <= 1'b0;
          rsp_done  <= 1'b1;
          rsp_err   <= (ev == EV_ERR);
          rsp_retry <= (ev == EV_RETRY);
        end else if (advance) begin
          state_q <= ST_BURST;
          if (before_last) bus_breq <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sbf_bus_master_chk.sv
module sbf_bus_master_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          bus_as,
  input logic          bus_ds,
  input logic          bus_rw,
  input logic [AW-1:0] bus_addr,
  input logic          bus_breq,
  input logic          bus_term,
  input logic          rsp_beat_valid,
  input logic          rsp_done,
  input logic          rsp_err,
  input logic          rsp_retry
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  a_r8_bus_frozen: assert property (@(posedge clk) disable iff (rst)
    past_ok && bus_as && $past(bus_as) |-> $stable(bus_addr) && $stable(bus_rw));

  a_r4_beat_needs_term: assert property (@(posedge clk) disable iff (rst)
    past_ok && rsp_beat_valid |-> $past(bus_term));

  a_r3_done_drops_strobes: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> !bus_as && !bus_ds);

  a_r5_status_single: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_err, rsp_retry}));

  a_r5_status_with_done: assert property (@(posedge clk) disable iff (rst)
    (rsp_err || rsp_retry) |-> rsp_done);

  a_r6_breq_read_only: assert property (@(posedge clk) disable iff (rst)
    bus_breq |-> bus_as && bus_rw);

  a_r2_ready_when_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !bus_as);
endmodule

bind sbf_bus_master sbf_bus_master_chk #(.AW(AW)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_ready      (req_ready),
  .bus_as         (bus_as),
  .bus_ds         (bus_ds),
  .bus_rw         (bus_rw),
  .bus_addr       (bus_addr),
  .bus_breq       (bus_breq),
  .bus_term       (bus_term),
  .rsp_beat_valid (rsp_beat_valid),
  .rsp_done       (rsp_done),
  .rsp_err        (rsp_err),
  .rsp_retry      (rsp_retry)
);

// File: tb/sbf_bus_master_tb_top.sv
module sbf_bus_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSTEP = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_fc = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0, req_fill = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        bus_as, bus_ds, bus_rw, bus_breq;
  logic [31:0] bus_addr, bus_wdata;
  logic [2:0]  bus_fc;
  logic [1:0]  bus_size;
  logic [31:0] bus_rdata = '0;
  logic        bus_term = 1'b0, bus_back = 1'b0, bus_berr = 1'b0, bus_halt = 1'b0, bus_cinh = 1'b0;
  logic        rsp_beat_valid, rsp_done, rsp_err, rsp_retry;
  logic [31:0] rsp_beat_data;
  logic [1:0]  rsp_beat_idx;
  logic [3:0]  rsp_mask;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // per-step control {term, back, berr, halt, cinh} and read data
  logic [4:0]  sc_ctl [NSTEP];
  logic [31:0] sc_dat [NSTEP];

  always #(CLK_PERIOD / 2) clk = ~clk;

  sbf_bus_master dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_fc(req_fc), .req_size(req_size),
    .req_write(req_write), .req_fill(req_fill), .req_wdata(req_wdata),
    .bus_as(bus_as), .bus_ds(bus_ds), .bus_rw(bus_rw), .bus_addr(bus_addr),
    .bus_fc(bus_fc), .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_breq(bus_breq),
    .bus_rdata(bus_rdata), .bus_term(bus_term), .bus_back(bus_back),
    .bus_berr(bus_berr), .bus_halt(bus_halt), .bus_cinh(bus_cinh),
    .rsp_beat_valid(rsp_beat_valid), .rsp_beat_data(rsp_beat_data),
    .rsp_beat_idx(rsp_beat_idx), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_retry(rsp_retry), .rsp_mask(rsp_mask)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_script();
    for (int i = 0; i < NSTEP; i++) begin
      sc_ctl[i] = 5'b0;
      sc_dat[i] = 32'hA5A5_0000 + 32'(i);
    end
  endtask

  task automatic set_step(input int i, input logic [4:0] ctl, input logic [31:0] d);
    sc_ctl[i] = ctl;
    sc_dat[i] = d;
  endtask

  task automatic drive_idle();
    {bus_term, bus_back, bus_berr, bus_halt, bus_cinh} = 5'b0;
  endtask

  task automatic run_xfer(input logic [31:0] addr, input bit fill, input bit wr);
    bit first = 1'b1, breq_e, done_e = 1'b0;
    int cnt = 0, start;
    logic [3:0] mask_e = '0;
    start = int'(addr[3:2]);
    breq_e = fill && !wr;
    @(negedge clk);
    chk("R2 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_addr = addr; req_fill = fill; req_write = wr;
    req_fc = 3'($urandom); req_size = 2'($urandom); req_wdata = $urandom;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 strobes up", 32'({bus_as, bus_ds}), 32'b11);
    chk("R2 address", bus_addr, addr);
    chk("R2 fc/size", 32'({bus_fc, bus_size}), 32'({req_fc, req_size}));
    chk("R2 ready low", 32'(req_ready), 32'd0);
    chk(wr ? "R11 rw write" : "R2 rw read", 32'(bus_rw), 32'(!wr));
    chk(wr ? "R11 no breq on write" : "R6 breq at start", 32'(bus_breq), 32'(breq_e));
    if (wr) chk("R11 write data", bus_wdata, req_wdata);
    for (int i = 0; i < NSTEP && !done_e; i++) begin
      bit t, b, e, h, c, bv_e = 1'b0, err_e = 1'b0, ret_e = 1'b0, was_first;
      int idx_e;
      {t, b, e, h, c} = sc_ctl[i];
      {bus_term, bus_back, bus_berr, bus_halt, bus_cinh} = sc_ctl[i];
      bus_rdata = sc_dat[i];
      was_first = first;
      idx_e = (start + cnt) % 4;
      if (e) begin
        if (h) ret_e = 1'b1; else err_e = 1'b1;
        done_e = 1'b1;
      end else if (!first && (c || !b)) begin
        done_e = 1'b1;
      end else if (t) begin
        bv_e = !wr;
        mask_e[idx_e] = 1'b1;
        cnt++;
        if (first) done_e = !(breq_e && b && !c);
        else       done_e = (cnt == 4);
        if (!done_e && cnt == 3) breq_e = 1'b0;
        first = 1'b0;
      end
      if (done_e) breq_e = 1'b0;
      @(negedge clk);
      chk(wr ? "R11 no beat on write" : "R4 beat valid", 32'(rsp_beat_valid), 32'(bv_e));
      if (bv_e) begin
        chk("R4 beat data", rsp_beat_data, sc_dat[i]);
        chk("R10 beat index", 32'(rsp_beat_idx), 32'(idx_e));
      end
      chk(was_first ? (fill && !wr ? "R7 done after first beat" : "R3 done") : "R8 done in burst",
          32'(rsp_done), 32'(done_e));
      chk("R5 error flag", 32'(rsp_err), 32'(err_e));
      chk("R5 retry flag", 32'(rsp_retry), 32'(ret_e));
      chk("R3 strobe", 32'(bus_as), 32'(!done_e));
      chk("R6 burst request", 32'(bus_breq), 32'(breq_e));
    end
    drive_idle();
    if (!done_e) chk("R3 transfer never finished", 32'd0, 32'd1);
    else begin
      chk("R9 R10 line mask", 32'(rsp_mask), 32'(mask_e));
      chk("R2 ready after end", 32'(req_ready), 32'd1);
    end
  endtask

  // control encodings
  localparam logic [4:0] C_NONE = 5'b00000;
  localparam logic [4:0] C_TERM = 5'b10000;
  localparam logic [4:0] C_TBK  = 5'b11000;
  localparam logic [4:0] C_WAIT = 5'b01000;
  localparam logic [4:0] C_ERR  = 5'b00100;
  localparam logic [4:0] C_RTY  = 5'b00110;
  localparam logic [4:0] C_CINH = 5'b11001;

  initial begin
    void'($urandom(32'd20240611));
    clear_script();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset outputs", 32'({bus_as, bus_ds, bus_breq, rsp_beat_valid, rsp_done, rsp_err, rsp_retry}), 32'd0);
    chk("R1 ready in reset", 32'(req_ready), 32'd1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", 32'({bus_as, bus_ds, bus_breq, rsp_done, req_ready}), 32'd1);

    // shortest single read
    clear_script(); set_step(0, C_TERM, 32'h1111_2222);
    run_xfer(32'h1000_0004, 1'b0, 1'b0);
    // wait states
    clear_script(); set_step(3, C_TERM, 32'h3333_4444);
    run_xfer(32'h1000_0008, 1'b0, 1'b0);
    // bus error after a wait, and error beating terminate
    clear_script(); set_step(1, C_ERR, '0);
    run_xfer(32'h2000_0000, 1'b0, 1'b0);
    clear_script(); set_step(0, C_ERR | C_TERM, '0);
    run_xfer(32'h2000_0010, 1'b1, 1'b0);
    // retry
    clear_script(); set_step(0, C_RTY, '0);
    run_xfer(32'h2000_0020, 1'b0, 1'b0);
    // full burst from word 2 with a mid wait
    clear_script();
    set_step(0, C_TBK, 32'hB0); set_step(1, C_WAIT, '0);
    set_step(2, C_TBK, 32'hB1); set_step(3, C_TBK, 32'hB2); set_step(4, C_TBK, 32'hB3);
    run_xfer(32'h3000_0008, 1'b1, 1'b0);
    // first beat without burst acknowledge
    clear_script(); set_step(0, C_TERM, 32'hC0);
    run_xfer(32'h3000_000C, 1'b1, 1'b0);
    // cache inhibit on first beat
    clear_script(); set_step(0, C_CINH, 32'hC1);
    run_xfer(32'h3000_0004, 1'b1, 1'b0);
    // inhibit mid-burst
    clear_script(); set_step(0, C_TBK, 32'hD0); set_step(1, C_TBK, 32'hD1); set_step(2, C_CINH, 32'hD2);
    run_xfer(32'h4000_0004, 1'b1, 1'b0);
    // acknowledge dropped with terminate high
    clear_script(); set_step(0, C_TBK, 32'hE0); set_step(1, C_TERM, 32'hE1);
    run_xfer(32'h4000_0000, 1'b1, 1'b0);
    // error and retry inside burst
    clear_script(); set_step(0, C_TBK, 32'hF0); set_step(1, C_TBK, 32'hF1); set_step(2, C_ERR | C_WAIT, '0);
    run_xfer(32'h4000_000C, 1'b1, 1'b0);
    clear_script(); set_step(0, C_TBK, 32'hF2); set_step(1, C_RTY | C_WAIT, '0);
    run_xfer(32'h4000_0008, 1'b1, 1'b0);
    // write with fill flag set
    clear_script(); set_step(1, C_TBK, '0);
    run_xfer(32'h5000_0004, 1'b1, 1'b1);

    // constrained random
    for (int n = 0; n < 80; n++) begin
      for (int i = 0; i < NSTEP; i++) begin
        bit t, b, e, h, c;
        t = ($urandom % 3) != 0;
        b = ($urandom % 12) != 0;
        e = ($urandom % 20) == 0;
        h = e && ($urandom % 2);
        c = ($urandom % 16) == 0;
        if (i >= 12) {t, b, e, h, c} = 5'b11000;
        set_step(i, {t, b, e, h, c}, $urandom);
      end
      run_xfer({$urandom} & 32'hFFFF_FFFC, 1'($urandom % 4 != 0), 1'($urandom % 5 == 0));
      if ($urandom % 3 == 0) @(negedge clk);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule